// File: doc/BRIEF.md
# Three-Channel Interval Timer Register Block

This block is a programmable interval timer with three 16-bit binary down-counters behind a byte-wide register port of four addresses. Addresses 0, 1 and 2 reach the counter value registers of channels 0, 1 and 2. Address 3 is the control register. A write to the control register picks a channel, sets how counter bytes are transferred and stores that channel's operating mode.

Each channel counts down by one on every cycle in which the tick enable input is high. Channel 0 drives the interrupt output. In the interrupt-on-terminal-count mode it raises the interrupt when its count reaches zero and then stops. In the rate-generator mode it reloads and keeps running, and it raises no interrupt. Any register access, read or write, clears a pending interrupt.

Software writes a control byte and then the count bytes. After that, the tick input drives the counting with no further register traffic.

Top module: `interval_timer`

## Requirements
- R1: A write to address 3 stores the whole byte. A read of address 3 returns the last control byte written, or 0x00 after reset. Read data is combinational from the address while `bus_sel` is high.
- R2: A control write stores bits 3:1 as the operating mode of the channel named by bits 7:6, and of no other channel. A channel field of 3 is treated as channel 0.
- R3: With control bits 5:4 = 01 (low byte), a counter write replaces bits 7:0 and keeps bits 15:8, and a counter read returns bits 7:0.
- R4: With control bits 5:4 = 10 (high byte), a counter write replaces bits 15:8 and keeps bits 7:0, and a counter read returns bits 15:8.
- R5: With control bits 5:4 = 11, the first counter access uses the low byte. Every counter access clears control bit 4, so every later access uses the high byte and a control read shows bits 5:4 = 10.
- R6: With control bits 5:4 = 00, counter writes change nothing and counter reads return 0x00.
- R7: After reset, the interrupt is low, every counter register is 0 and all channels are in rate-generator mode (mode 010).
- R8: A counter write loads that channel's count from the updated register value. With channel 0 in mode 000 (interrupt on terminal count) and a loaded value N, the interrupt rises right after the Nth tick. The count then stops and raises no further interrupt until the channel is loaded again.
- R9: In mode 010 (rate generator) the count reloads from the register value on the tick at which it reaches one, and channel 0 raises no interrupt.
- R10: Any access to any address, read or write, clears the pending interrupt. A terminal event in the same cycle as an access wins.
- R11: A loaded value of 0 counts 65536 ticks.
- R12: Only channel 0 drives the interrupt. Channels 1 and 2 in mode 000 never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 to 2 are counters, 3 is control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| irq | output | 1 | Channel 0 interrupt, level, held until an access |

## Verification
The bench walks the two-byte access sequence and reads the control byte back. A design that never dropped the low-byte bit would return the low byte forever and show 0x74 instead of 0x64. It programs channel 0 through a channel field of 3 and checks that a mode write to channel 1 leaves channel 0 untouched. A wrong decode would either give no interrupt or give one in rate-generator mode. It runs a rate-generator count past its reload and then switches to terminal-count mode. A missing reload shows up as an interrupt at the wrong tick. It also checks that the count stops after the terminal interrupt, that a read alone clears the interrupt, and that a loaded zero counts the full 65536 ticks rather than firing at once.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int NUM_CHAN = 3;
  localparam int CNT_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int MODE_W   = 3;

  typedef enum logic [1:0] {
    AM_NONE = 2'b00,
    AM_LO   = 2'b01,
    AM_HI   = 2'b10,
    AM_LOHI = 2'b11
  } acc_mode_e;

  localparam logic [MODE_W-1:0] OPM_TERM = 3'b000;
  localparam logic [MODE_W-1:0] OPM_RATE = 3'b010;

  // channel field 3 has no channel behind it and folds onto channel 0
  function automatic logic [1:0] chan_index(input logic [1:0] field);
    return (field == 2'd3) ? 2'd0 : field;
  endfunction

  // new register value after a byte write under the given access mode
  function automatic logic [CNT_W-1:0] merge_byte(input logic [CNT_W-1:0] old_v,
                                                  input acc_mode_e am,
                                                  input logic [BYTE_W-1:0] b);
    case (am)
      AM_LO, AM_LOHI: return {old_v[CNT_W-1:BYTE_W], b};
      AM_HI:          return {b, old_v[BYTE_W-1:0]};
      default:        return old_v;
    endcase
  endfunction

  // byte returned for a counter read under the given access mode
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v,
                                                  input acc_mode_e am);
    case (am)
      AM_LO, AM_LOHI: return v[BYTE_W-1:0];
      AM_HI:          return v[CNT_W-1:BYTE_W];
      default:        return '0;
    endcase
  endfunction
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ctrl_wr,
  input  logic                           cnt_acc,
  input  logic [BYTE_W-1:0]              wdata,
  output logic [BYTE_W-1:0]              ctrl_q,
  output acc_mode_e                      am,
  output logic [NUM_CHAN-1:0][MODE_W-1:0] mode_q
);
  assign am = acc_mode_e'(ctrl_q[5:4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= wdata;
    end else if (cnt_acc && am == AM_LOHI) begin
      ctrl_q[4] <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_mode
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q[i] <= OPM_RATE;
      end else if (ctrl_wr && chan_index(wdata[7:6]) == 2'(i)) begin
        mode_q[i] <= wdata[3:1];
      end
    end
  end

  p_ctrl_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q == $past(wdata));

  p_seq_to_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_acc && !ctrl_wr && am == AM_LOHI) |=> am == AM_HI);
endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  acc_mode_e         am,
  input  logic              tick,
  input  logic [MODE_W-1:0] opmode,
  output logic [CNT_W-1:0]  prog_q,
  output logic              term
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             load;
  logic [CNT_W-1:0] prog_nx;

  assign load    = wr_en && (am != AM_NONE);
  assign prog_nx = merge_byte(prog_q, am, wdata);
  assign term    = tick && armed_q && !load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      prog_q  <= prog_nx;
      cnt_q   <= prog_nx;
      armed_q <= 1'b1;
    end else if (term) begin
      if (opmode == OPM_TERM) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= prog_q;
      end
    end else if (tick && armed_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  p_low_keeps_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && am == AM_LO) |=> prog_q[CNT_W-1:BYTE_W] == $past(prog_q[CNT_W-1:BYTE_W]));

  p_term_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (term && opmode == OPM_TERM) |=> (cnt_q == '0 && !armed_q));

  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !load) |=> $stable(cnt_q));

  p_rate_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (term && opmode != OPM_TERM) |=> cnt_q == $past(prog_q));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tick_en,
  output logic       irq
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic                            ctrl_wr;
  logic                            cnt_acc;
  logic [BYTE_W-1:0]               ctrl_q;
  acc_mode_e                       am;
  logic [NUM_CHAN-1:0][MODE_W-1:0] mode_q;
  logic [NUM_CHAN-1:0][CNT_W-1:0]  prog_w;
  logic [NUM_CHAN-1:0]             term_w;
  logic                            irq_set;

  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == CTRL_ADDR);
  assign cnt_acc = bus_sel && (bus_addr != CTRL_ADDR);

  timer_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .cnt_acc (cnt_acc),
    .wdata   (bus_wdata),
    .ctrl_q  (ctrl_q),
    .am      (am),
    .mode_q  (mode_q)
  );

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
    timer_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_sel && bus_wr && bus_addr == 2'(i)),
      .wdata  (bus_wdata),
      .am     (am),
      .tick   (tick_en),
      .opmode (mode_q[i]),
      .prog_q (prog_w[i]),
      .term   (term_w[i])
    );
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = pick_byte(prog_w[0], am);
      2'd1:    bus_rdata = pick_byte(prog_w[1], am);
      2'd2:    bus_rdata = pick_byte(prog_w[2], am);
      default: bus_rdata = ctrl_q;
    endcase
  end

  assign irq_set = term_w[0] && (mode_q[0] == OPM_TERM);

  always_ff @(posedge clk) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (bus_sel) irq <= 1'b0;
  end

  p_irq_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !irq_set) |=> !irq);

  p_irq_from_ch0_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(term_w[0]));
endmodule

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tick_en = 1'b0;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk;

  interval_timer u_interval_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R7 irq after reset", {7'd0, irq}, 8'h00);
    rd(2'd3, v); check("R7 R1 control after reset", v, 8'h00);
    wr(2'd3, 8'h54);
    rd(2'd1, v); check("R7 counter after reset", v, 8'h00);
  endtask

  task automatic t_ctrl_readback();
    logic [7:0] v;
    wr(2'd3, 8'h96);
    rd(2'd3, v); check("R1 control readback", v, 8'h96);
  endtask

  task automatic t_byte_modes();
    logic [7:0] v;
    wr(2'd3, 8'h90);
    wr(2'd2, 8'hAB);
    rd(2'd2, v); check("R3 low byte read", v, 8'hAB);
    wr(2'd3, 8'hA0);
    wr(2'd2, 8'hCD);
    rd(2'd2, v); check("R4 high byte read", v, 8'hCD);
    wr(2'd3, 8'h90);
    rd(2'd2, v); check("R4 low byte kept", v, 8'hAB);
    wr(2'd3, 8'h84);
    wr(2'd2, 8'h55);
    rd(2'd2, v); check("R6 mode 00 read", v, 8'h00);
    wr(2'd3, 8'h90);
    rd(2'd2, v); check("R6 write ignored low", v, 8'hAB);
    wr(2'd3, 8'hA0);
    rd(2'd2, v); check("R6 write ignored high", v, 8'hCD);
  endtask

  task automatic t_two_byte();
    logic [7:0] v;
    wr(2'd3, 8'h74);
    wr(2'd1, 8'h34);
    wr(2'd1, 8'h12);
    rd(2'd1, v); check("R5 later access is high", v, 8'h12);
    rd(2'd3, v); check("R5 low bit dropped", v, 8'h64);
    wr(2'd3, 8'h54);
    rd(2'd1, v); check("R5 first access was low", v, 8'h34);
  endtask

  task automatic t_term_count();
    logic [7:0] v;
    wr(2'd3, 8'h10);
    wr(2'd0, 8'd5);
    ticks(4); check("R8 no irq before N", {7'd0, irq}, 8'h00);
    ticks(1); check("R8 irq at N", {7'd0, irq}, 8'h01);
    ticks(3); check("R10 irq held without access", {7'd0, irq}, 8'h01);
    rd(2'd3, v); check("R10 control read clears", {7'd0, irq}, 8'h00);
    ticks(10); check("R8 count stopped", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'd2);
    ticks(2); check("R8 reload rearms", {7'd0, irq}, 8'h01);
    rd(2'd2, v); check("R10 counter read clears", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_select() ;
    wr(2'd3, 8'h14);
    wr(2'd3, 8'hD0);
    wr(2'd0, 8'd3);
    ticks(3); check("R2 field 3 reaches channel 0", {7'd0, irq}, 8'h01);
    wr(2'd3, 8'h14);
    wr(2'd3, 8'h50);
    wr(2'd0, 8'd3);
    ticks(3); check("R2 channel 0 mode untouched", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'd2);
    ticks(4); check("R12 channel 1 gives no irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_rate();
    wr(2'd3, 8'h14);
    wr(2'd0, 8'd4);
    ticks(6); check("R9 no irq in rate mode", {7'd0, irq}, 8'h00);
    wr(2'd3, 8'h10);
    ticks(1); check("R9 reload position early", {7'd0, irq}, 8'h00);
    ticks(1); check("R9 reload position", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_full_range();
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h00);
    ticks(65535); check("R11 zero not yet done", {7'd0, irq}, 8'h00);
    ticks(1); check("R11 zero is 65536", {7'd0, irq}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_readback();
    t_byte_modes();
    t_two_byte();
    t_term_count();
    t_select();
    t_rate();
    t_full_range();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule